// File: doc/BRIEF.md
# LCD Panel Sync Timing Generator

This block produces the timing skeleton for a 320x240 TFT panel fed over a parallel RGB port. Running from a single pixel-port clock, it counts ticks across each line and lines across each frame, and from those two counts it drives active-low horizontal and vertical sync pulses. It also drives a data-enable window and a pixel-request strobe that tells the upstream pixel source when to present each active pixel.

Narrow buses need more than one clock per pixel, so the clocks-per-pixel setting is a parameter. The line period, the sync widths and the active window all scale with it. The position of the first active tick also includes a fixed correction for the external packing pipeline. Each frame has four blanking lines, two above the 240 active lines and two below them.

A synchronous enable starts both counters together from zero. Removing the enable parks both syncs high and clears the counters. Single-cycle line and frame markers are provided for the logic that consumes the timing.

Top module: `lcd_sync_gen`

## Requirements
- R1: While rst_n is low, and after reset until en is first sampled high, the outputs are idle: hsync_n=1, vsync_n=1, de=0, pix_req=0, line_start=0, frame_start=0.
- R2: The line period is H = LINE_PIX*CLK_PER_PIX ticks (336 by default). line_start pulses for one cycle on tick 0 of every line. The first pulse comes in the cycle after the first clock edge at which en is sampled high.
- R3: hsync_n is low for exactly the first HS_PIX*CLK_PER_PIX ticks of every line (2*CPP) and high for the rest of the line.
- R4: vsync_n is low for ticks 0 to VS_PIX*CLK_PER_PIX-1 of line 0 of each frame, and high at every other tick. A frame holds ACT_H+BLANK_LINES lines (244 by default).
- R5: de is high on ticks S to S+ACT_W*CLK_PER_PIX-1 of each active line, where S = FIRST_PIX*CLK_PER_PIX + C. The correction C is 0, 3 or 5 for 1, 2 or 3 clocks per pixel. With the defaults S is 7.
- R6: pix_req is high on the first tick of each pixel inside the de window, that is when de=1 and (tick-S) mod CLK_PER_PIX = 0. At one clock per pixel pix_req equals de.
- R7: frame_start pulses for one cycle on tick 0 of line 0 and repeats every H*(ACT_H+BLANK_LINES) ticks. It is always accompanied by line_start.
- R8: In the cycle after en is sampled low, all outputs are idle as in R1. When en returns, timing restarts from tick 0 of line 0.
- R9: Lines 0 to BLANK_LINES/2-1 and the last BLANK_LINES/2 lines of a frame carry no de. The active lines are 2 to 241 by default, so a default frame carries exactly 76800 de ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-port clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Synchronous run enable |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| de | output | 1 | Active-data window |
| pix_req | output | 1 | One strobe per active pixel, asking for the next pixel |
| line_start | output | 1 | One-cycle marker on tick 0 of each line |
| frame_start | output | 1 | One-cycle marker on tick 0 of each frame |

## Verification
The assertions assume that en is a clean synchronous level, that rst_n is the only asynchronous input, and that the parameters pass the elaboration checks. Under those assumptions the checker can mirror run state from en alone and time line and frame periods with counters of its own. The stimulus changes en only on falling clock edges. It drops en mid-frame for several cycles and for a single cycle, so restarts are exercised from arbitrary positions. Three geometries run from the same enable pattern: one, two and three clocks per pixel.

// File: rtl/lcd_sync_pkg.sv
package lcd_sync_pkg;

   // Tick offset added to the first active tick to absorb the external
   // byte-packing pipeline of narrow buses.
   function automatic int pipe_corr(input int cpp);
      case (cpp)
         1:       return 0;
         2:       return 3;
         3:       return 5;
         default: return 0;
      endcase
   endfunction

   function automatic int cnt_width(input int modulus);
      return (modulus > 1) ? $clog2(modulus) : 1;
   endfunction

   typedef struct packed {
      logic hs_n;
      logic vs_n;
      logic de;
      logic ls;
      logic fs;
   } lcd_sync_t;

endpackage

// File: rtl/lcd_wrap_counter.sv
module lcd_wrap_counter #(
   parameter int MOD = 2,
   parameter int W   = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         step,
   output logic [W-1:0] cnt,
   output logic         last
);

   localparam logic [W-1:0] MAXV = W'(MOD - 1);

   assign last = (cnt == MAXV);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt <= '0;
      else if (clr)     cnt <= '0;
      else if (step)    cnt <= last ? '0 : cnt + 1'b1;
   end

endmodule

// File: rtl/lcd_window_decode.sv
module lcd_window_decode
   import lcd_sync_pkg::*;
#(
   parameter int HW      = 9,
   parameter int VW      = 8,
   parameter int HS_W    = 2,
   parameter int VS_W    = 2,
   parameter int H_START = 7,
   parameter int H_ACT   = 320,
   parameter int V_TOP   = 2,
   parameter int ACT_H   = 240
) (
   input  logic          run,
   input  logic [HW-1:0] hcnt,
   input  logic [VW-1:0] vcnt,
   output lcd_sync_t     sy
);

   localparam logic [HW-1:0] C_HS    = HW'(HS_W);
   localparam logic [HW-1:0] C_VS    = HW'(VS_W);
   localparam logic [HW-1:0] C_HFST  = HW'(H_START);
   localparam logic [HW-1:0] C_HLST  = HW'(H_START + H_ACT - 1);
   localparam logic [VW-1:0] C_VLST  = VW'(V_TOP + ACT_H - 1);

   logic h_in, v_in, line0, tick0;

   assign h_in  = (hcnt >= C_HFST) && (hcnt <= C_HLST);
   assign tick0 = (hcnt == '0);
   assign line0 = (vcnt == '0);

   generate
      if (V_TOP == 0) begin : g_vtop_zero
         assign v_in = (vcnt <= C_VLST);
      end else begin : g_vtop_pos
         localparam logic [VW-1:0] C_VFST = VW'(V_TOP);
         assign v_in = (vcnt >= C_VFST) && (vcnt <= C_VLST);
      end
   endgenerate

   always_comb begin
      sy.hs_n = 1'b1;
      sy.vs_n = 1'b1;
      sy.de   = 1'b0;
      sy.ls   = 1'b0;
      sy.fs   = 1'b0;
      if (run) begin
         sy.hs_n = !(hcnt < C_HS);
         sy.vs_n = !(line0 && (hcnt < C_VS));
         sy.de   = h_in && v_in;
         sy.ls   = tick0;
         sy.fs   = tick0 && line0;
      end
   end

endmodule

// File: rtl/lcd_pix_phase.sv
module lcd_pix_phase #(
   parameter int CPP     = 1,
   parameter int HW      = 9,
   parameter int H_START = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adv,
   input  logic [HW-1:0] hcnt,
   input  logic          de,
   output logic          pix_req
);

   generate
      if (CPP == 1) begin : g_single
         logic unused_ph;
         assign unused_ph = ^{clk, rst_n, adv, hcnt};
         assign pix_req   = de;
      end else begin : g_multi
         localparam int PW = $clog2(CPP);
         localparam logic [PW-1:0] PH_LAST = PW'(CPP - 1);
         localparam logic [HW-1:0] C_PRE   = HW'(H_START - 1);
         logic [PW-1:0] ph;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                ph <= '0;
            else if (!adv)             ph <= '0;
            else if (hcnt == C_PRE)    ph <= '0;
            else if (ph == PH_LAST)    ph <= '0;
            else                       ph <= ph + 1'b1;
         end

         assign pix_req = de && (ph == '0);
      end
   endgenerate

endmodule

// File: rtl/lcd_sync_gen.sv
module lcd_sync_gen
   import lcd_sync_pkg::*;
#(
   parameter int CLK_PER_PIX = 1,
   parameter int ACT_W       = 320,
   parameter int ACT_H       = 240,
   parameter int LINE_PIX    = 336,
   parameter int HS_PIX      = 2,
   parameter int VS_PIX      = 2,
   parameter int FIRST_PIX   = 7,
   parameter int BLANK_LINES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic hsync_n,
   output logic vsync_n,
   output logic de,
   output logic pix_req,
   output logic line_start,
   output logic frame_start
);

   localparam int CORR     = pipe_corr(CLK_PER_PIX);
   localparam int H_PERIOD = LINE_PIX * CLK_PER_PIX;
   localparam int HS_W     = HS_PIX * CLK_PER_PIX;
   localparam int VS_W     = VS_PIX * CLK_PER_PIX;
   localparam int H_START  = FIRST_PIX * CLK_PER_PIX + CORR;
   localparam int H_ACT    = ACT_W * CLK_PER_PIX;
   localparam int V_LINES  = ACT_H + BLANK_LINES;
   localparam int V_TOP    = BLANK_LINES / 2;
   localparam int HW       = cnt_width(H_PERIOD);
   localparam int VW       = cnt_width(V_LINES);

   generate
      if (CLK_PER_PIX < 1 || CLK_PER_PIX > 3) begin : g_bad_cpp
         $error("lcd_sync_gen: CLK_PER_PIX must be 1, 2 or 3");
      end
      if (H_START + H_ACT > H_PERIOD) begin : g_bad_hwin
         $error("lcd_sync_gen: active window exceeds the line period");
      end
      if (HS_W < 1 || HS_W >= H_START) begin : g_bad_hs
         $error("lcd_sync_gen: hsync width must be nonzero and end before the window");
      end
      if (VS_W < 1 || VS_W > H_PERIOD) begin : g_bad_vs
         $error("lcd_sync_gen: vsync width must fit in one line");
      end
      if (ACT_H < 1 || BLANK_LINES < 0) begin : g_bad_v
         $error("lcd_sync_gen: invalid vertical geometry");
      end
   endgenerate

   logic          run;
   logic          adv;
   logic [HW-1:0] hcnt;
   logic [VW-1:0] vcnt;
   logic          hlast;
   logic          vlast_unused;
   lcd_sync_t     sy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) run <= 1'b0;
      else        run <= en;
   end

   assign adv = run & en;

   lcd_wrap_counter #(.MOD(H_PERIOD), .W(HW)) u_hcnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (!adv),
      .step  (1'b1),
      .cnt   (hcnt),
      .last  (hlast)
   );

   lcd_wrap_counter #(.MOD(V_LINES), .W(VW)) u_vcnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (!adv),
      .step  (hlast),
      .cnt   (vcnt),
      .last  (vlast_unused)
   );

   lcd_window_decode #(
      .HW(HW), .VW(VW), .HS_W(HS_W), .VS_W(VS_W),
      .H_START(H_START), .H_ACT(H_ACT), .V_TOP(V_TOP), .ACT_H(ACT_H)
   ) u_dec (
      .run  (run),
      .hcnt (hcnt),
      .vcnt (vcnt),
      .sy   (sy)
   );

   lcd_pix_phase #(.CPP(CLK_PER_PIX), .HW(HW), .H_START(H_START)) u_phase (
      .clk     (clk),
      .rst_n   (rst_n),
      .adv     (adv),
      .hcnt    (hcnt),
      .de      (sy.de),
      .pix_req (pix_req)
   );

   assign hsync_n     = sy.hs_n;
   assign vsync_n     = sy.vs_n;
   assign de          = sy.de;
   assign line_start  = sy.ls;
   assign frame_start = sy.fs;

endmodule

// File: rtl/lcd_sync_gen_chk.sv
module lcd_sync_gen_chk #(
   parameter int H_PERIOD = 336,
   parameter int F_PERIOD = 81984,
   parameter int HS_W     = 2,
   parameter int H_START  = 7,
   parameter int H_ACT    = 320
) (
   input logic clk,
   input logic rst_n,
   input logic en,
   input logic hsync_n,
   input logic vsync_n,
   input logic de,
   input logic pix_req,
   input logic line_start,
   input logic frame_start
);

   logic act, lseen, fseen;
   int   tpos, fpos, pos;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act <= 1'b0; lseen <= 1'b0; fseen <= 1'b0; tpos <= 0; fpos <= 0;
      end else begin
         act <= en;
         if (!act) begin
            lseen <= 1'b0; fseen <= 1'b0; tpos <= 0; fpos <= 0;
         end else begin
            if (line_start)  begin lseen <= 1'b1; tpos <= 1; end
            else             tpos <= tpos + 1;
            if (frame_start) begin fseen <= 1'b1; fpos <= 1; end
            else             fpos <= fpos + 1;
         end
      end
   end

   assign pos = line_start ? 0 : tpos;

   a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
      !act |-> (hsync_n && vsync_n && !de && !pix_req && !line_start && !frame_start));

   a_r2_line_period: assert property (@(posedge clk) disable iff (!rst_n)
      (act && line_start && lseen) |-> (tpos == H_PERIOD));

   a_r3_hsync_width: assert property (@(posedge clk) disable iff (!rst_n)
      (act && (line_start || lseen)) |-> (hsync_n == (pos >= HS_W)));

   a_r4_vsync_at_frame: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |-> !vsync_n);

   a_r5_de_window: assert property (@(posedge clk) disable iff (!rst_n)
      (de && (line_start || lseen)) |-> (pos >= H_START && pos < H_START + H_ACT));

   a_r6_req_in_window: assert property (@(posedge clk) disable iff (!rst_n)
      pix_req |-> de);

   a_r7_frame_period: assert property (@(posedge clk) disable iff (!rst_n)
      (act && frame_start && fseen) |-> (fpos == F_PERIOD));

   a_r7_frame_on_line: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |-> line_start);

   a_r8_stop_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (hsync_n && vsync_n && !de && !line_start));

endmodule

bind lcd_sync_gen lcd_sync_gen_chk #(
   .H_PERIOD (H_PERIOD),
   .F_PERIOD (H_PERIOD * V_LINES),
   .HS_W     (HS_W),
   .H_START  (H_START),
   .H_ACT    (H_ACT)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .en          (en),
   .hsync_n     (hsync_n),
   .vsync_n     (vsync_n),
   .de          (de),
   .pix_req     (pix_req),
   .line_start  (line_start),
   .frame_start (frame_start)
);

// File: tb/tb_lcd_sync_gen.sv
module tb_lcd_sync_gen;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en = 1'b0;

   always #4 clk = ~clk;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;
   bit ever_en = 1'b0;

   logic [5:0] obs [3];
   logic hs [3], vs [3], dv [3], pr [3], ls [3], fs [3];

   lcd_sync_gen dut (
      .clk(clk), .rst_n(rst_n), .en(en),
      .hsync_n(hs[0]), .vsync_n(vs[0]), .de(dv[0]), .pix_req(pr[0]),
      .line_start(ls[0]), .frame_start(fs[0]));

   lcd_sync_gen #(.CLK_PER_PIX(2), .ACT_W(4), .ACT_H(3), .LINE_PIX(14)) dut2 (
      .clk(clk), .rst_n(rst_n), .en(en),
      .hsync_n(hs[1]), .vsync_n(vs[1]), .de(dv[1]), .pix_req(pr[1]),
      .line_start(ls[1]), .frame_start(fs[1]));

   lcd_sync_gen #(.CLK_PER_PIX(3), .ACT_W(4), .ACT_H(3), .LINE_PIX(14)) dut3 (
      .clk(clk), .rst_n(rst_n), .en(en),
      .hsync_n(hs[2]), .vsync_n(vs[2]), .de(dv[2]), .pix_req(pr[2]),
      .line_start(ls[2]), .frame_start(fs[2]));

   always_comb begin
      for (int i = 0; i < 3; i++) obs[i] = {hs[i], vs[i], dv[i], pr[i], ls[i], fs[i]};
   end

   // Geometry of each instance: clocks per pixel, line pixels, width, height.
   int g_cpp [3] = '{1, 2, 3};
   int g_lp  [3] = '{336, 14, 14};
   int g_aw  [3] = '{320, 4, 4};
   int g_ah  [3] = '{240, 3, 3};

   // Expected {hsync_n, vsync_n, de, pix_req, line_start, frame_start}.
   function automatic logic [5:0] ref_out(int cpp, int lp, int aw, int ah, bit run, int k);
      int hp, vl, t, l, s, corr;
      logic [5:0] r;
      if (!run) return 6'b110000;
      hp   = lp * cpp;
      vl   = ah + 4;
      t    = k % hp;
      l    = (k / hp) % vl;
      corr = (cpp == 1) ? 0 : (cpp == 2) ? 3 : 5;
      s    = 7 * cpp + corr;
      r[5] = !(t < 2 * cpp);
      r[4] = !(l == 0 && t < 2 * cpp);
      r[3] = (l >= 2 && l < 2 + ah && t >= s && t < s + aw * cpp);
      r[2] = r[3] && (((t - s) % cpp) == 0);
      r[1] = (t == 0);
      r[0] = (t == 0 && l == 0);
      return r;
   endfunction

   function automatic string tag_of(int b, bit run, bit ever);
      if (!ever) return "R1";
      if (!run)  return "R8";
      case (b)
         5: return "R3";
         4: return "R4";
         3: return "R5";
         2: return "R6";
         1: return "R2";
         default: return "R7";
      endcase
   endfunction

   // Behavioural model of run state and ticks since start.
   bit run_m;
   int k;
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_m <= 1'b0; k <= 0;
      end else begin
         run_m <= en;
         k     <= (en && run_m) ? k + 1 : 0;
      end
   end

   int  de_cnt [3], pr_cnt [3], ls_cnt [3];
   bit  have [3];

   always @(negedge clk) begin
      if (!done) begin
         for (int i = 0; i < 3; i++) begin
            logic [5:0] e;
            e = ref_out(g_cpp[i], g_lp[i], g_aw[i], g_ah[i], run_m, k);
            n_chk++;
            if (obs[i] !== e) begin
               int b;
               b = 0;
               for (int j = 5; j >= 0; j--) if (obs[i][j] !== e[j]) begin b = j; break; end
               n_fail++;
               $display("FAIL %s inst%0d k=%0d actual=%b expected=%b",
                        tag_of(b, run_m, ever_en), i, k, obs[i], e);
            end
            // Per-frame totals: R9 blanking, R2 line count, R6 request count.
            if (!run_m) have[i] = 1'b0;
            else if (fs[i]) begin
               if (have[i]) begin
                  n_chk++;
                  if (de_cnt[i] != g_aw[i] * g_cpp[i] * g_ah[i] || ls_cnt[i] != g_ah[i] + 4 ||
                      pr_cnt[i] != g_aw[i] * g_ah[i]) begin
                     n_fail++;
                     $display("FAIL R9/R2/R6 inst%0d frame totals actual de=%0d ls=%0d req=%0d expected de=%0d ls=%0d req=%0d",
                              i, de_cnt[i], ls_cnt[i], pr_cnt[i],
                              g_aw[i] * g_cpp[i] * g_ah[i], g_ah[i] + 4, g_aw[i] * g_ah[i]);
                  end
               end
               have[i]   = 1'b1;
               de_cnt[i] = 0; pr_cnt[i] = 0; ls_cnt[i] = 1;
            end else begin
               de_cnt[i] += int'(dv[i]);
               pr_cnt[i] += int'(pr[i]);
               ls_cnt[i] += int'(ls[i]);
            end
         end
      end
   end

   task automatic finish_run();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog (all) actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      en    = 1'b0;
      rst_n = 1'b0;
      repeat (5) @(negedge clk);
      // R1: idle outputs during reset.
      n_chk++;
      if (obs[0] !== 6'b110000) begin
         n_fail++;
         $display("FAIL R1 reset state actual=%b expected=110000", obs[0]);
      end
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      en = 1'b1;
      ever_en = 1'b1;
      // R2/R7: the first markers come one cycle after en is sampled.
      @(negedge clk);
      n_chk++;
      if (ls[0] !== 1'b1 || fs[0] !== 1'b1 || hs[0] !== 1'b0) begin
         n_fail++;
         $display("FAIL R2 first line actual ls=%b fs=%b hs=%b expected 1 1 0", ls[0], fs[0], hs[0]);
      end
      repeat (82500) @(negedge clk);
      en = 1'b0;                        // R8: stop mid-frame
      repeat (7) @(negedge clk);
      en = 1'b1;
      repeat (1500) @(negedge clk);
      en = 1'b0;                        // R8: single-cycle drop
      @(negedge clk);
      en = 1'b1;
      repeat (3000) @(negedge clk);
      finish_run();
   end

endmodule